// File: doc/BRIEF.md
# Phase-Offset Sample Strobe Generator

This block produces the two sample-ready strobes of a dual-channel oversampled converter. Both channels run at one oversampling ratio (OSR) chosen from 32, 64, 128 or 256. The decimation window of channel 0 is moved against that of channel 1 by a signed count of modulator clock cycles. The count comes from an 8-bit phase setting. Each strobe is high for one modulator clock cycle per output sample. A third output shows, sign-extended, the signed delay currently in force.

The phase setting is written once in its OSR-256 form. The bit that carries the sign then moves with the ratio: bit 4 + `ratio_sel`. Bits above it are ignored, and the bits below it give the magnitude. The same setting is therefore read again by truncation when the ratio changes and never has to be rewritten. A new phase or ratio is adopted only at the end of a channel 1 period, so a period is never cut short or given two strobes. Delays of whole output samples are left to the consumer, which adds them on top of the modulator-cycle offset.

Top module: `phase_strobe_gen`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, both strobes are 0 and `delay_eff` is 0.
- R2: `ratio_sel` codes 0, 1, 2, 3 select OSR 32, 64, 128, 256. `strobe_ch1` is high for one cycle every OSR cycles. Counting the cycle that follows the first rising edge after reset release as cycle 1, its first pulse falls in cycle OSR.
- R3: `delay_eff` is the sign-extended value of `phase_cfg[4+ratio_sel:0]`, with bit 4+`ratio_sel` as the sign. Bits above the sign bit have no effect on it (for example 0x25 gives +5 at code 0, and 0xFF gives -1 at code 2).
- R4: In steady state, for a delay d, `strobe_ch0` is high in the cycle d cycles after a `strobe_ch1` pulse when d >= 0, and |d| cycles before the next `strobe_ch1` pulse when d < 0. Measured from reset, its first pulse falls in cycle OSR + (d mod OSR).
- R5: After reset, no `strobe_ch0` pulse comes before the first `strobe_ch1` pulse.
- R6: Changes on `phase_cfg` or `ratio_sel` leave `delay_eff` and the strobe timing unchanged until the cycle after the next `strobe_ch1` pulse.
- R7: Between two consecutive `strobe_ch1` pulses there is at most one `strobe_ch0` pulse. A pulse that coincides with a `strobe_ch1` pulse counts toward the period that pulse ends.
- R8: When only `ratio_sel` changes, the held `phase_cfg` is read again with the new sign bit at the next period boundary, and the new period length and offset follow from it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Modulator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phase_cfg | input | 8 | Phase setting in OSR-256 two's complement form |
| ratio_sel | input | 2 | OSR select: 0=32, 1=64, 2=128, 3=256 |
| strobe_ch0 | output | 1 | Channel 0 sample-ready pulse |
| strobe_ch1 | output | 1 | Channel 1 sample-ready pulse |
| delay_eff | output | 8 | Signed delay in force, sign-extended |

## Verification
The hardest state to reach is a ratio change made while a period is running, with the phase setting left as it is. A correct design must keep the old delay and period until the boundary, then read the same setting with a different sign bit. The stimulus resets at OSR 256 with 0xC5 (-59). Part-way through the period it switches to OSR 64, where the same setting means +5. It then changes the phase in the middle of the following period to reach a negative offset at the shorter ratio. For each change it checks `delay_eff` on the cycles on both sides of the `strobe_ch1` pulse, and the strobe positions that follow.

// File: rtl/phstb_pkg.sv
package phstb_pkg;

    localparam int DEF_PHASE_W  = 8;
    localparam int DEF_SEL_W    = 2;
    localparam int DEF_MIN_LOG2 = 5;

    typedef enum logic [1:0] {
        RATIO_32  = 2'd0,
        RATIO_64  = 2'd1,
        RATIO_128 = 2'd2,
        RATIO_256 = 2'd3
    } ratio_e;

    // log2 of the oversampling ratio for a select code
    function automatic int ratio_log2(input int sel, input int min_log2);
        return min_log2 + sel;
    endfunction

endpackage

// File: rtl/phstb_decode.sv
// Reads the held phase setting with the sign bit placed by the ratio.
// Also gives the last count of a period and the channel 0 match count.
module phstb_decode #(
    parameter int PHASE_W  = phstb_pkg::DEF_PHASE_W,
    parameter int SEL_W    = phstb_pkg::DEF_SEL_W,
    parameter int MIN_LOG2 = phstb_pkg::DEF_MIN_LOG2
) (
    input  logic [PHASE_W-1:0] phase_i,
    input  logic [SEL_W-1:0]   sel_i,
    output logic [PHASE_W-1:0] delay_o,
    output logic [PHASE_W-1:0] last_o,
    output logic [PHASE_W-1:0] match_o
);
    localparam int NUM_RATIOS = 1 << SEL_W;

    logic [PHASE_W-1:0] ext_w  [NUM_RATIOS];
    logic [PHASE_W-1:0] last_w [NUM_RATIOS];

    for (genvar r = 0; r < NUM_RATIOS; r++) begin : g_ratio
        localparam int FW = phstb_pkg::ratio_log2(r, MIN_LOG2);
        if (FW >= PHASE_W) begin : g_full
            assign ext_w[r] = phase_i;
        end else begin : g_trunc
            assign ext_w[r] = {{(PHASE_W-FW){phase_i[FW-1]}}, phase_i[FW-1:0]};
        end
        assign last_w[r] = PHASE_W'((1 << FW) - 1);
    end

    always_comb begin
        delay_o = ext_w[sel_i];
        last_o  = last_w[sel_i];
        // (OSR-1 + d) mod OSR; OSR is a power of two, so a mask does the modulo
        match_o = (last_o + delay_o) & last_o;
    end

endmodule

// File: rtl/phstb_counter.sv
// Modulo-OSR position counter shared by both channels.
module phstb_counter #(
    parameter int CNT_W = phstb_pkg::DEF_PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic [CNT_W-1:0] last_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             wrap_o
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d    = s_q;
        wrap_o = 1'b0;
        if (hold_i) begin
            s_d.cnt = '0;
        end else if (s_q.cnt == last_i) begin
            s_d.cnt = '0;
            wrap_o  = 1'b1;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o = s_q.cnt;

endmodule

// File: rtl/phstb_ch0_gate.sv
// Channel 0 strobe: fires at the match count, held off until channel 1 has wrapped once.
module phstb_ch0_gate #(
    parameter int CNT_W = phstb_pkg::DEF_PHASE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hold_i,
    input  logic             wrap_i,
    input  logic [CNT_W-1:0] cnt_i,
    input  logic [CNT_W-1:0] match_i,
    output logic             strobe_o
);
    typedef struct packed {
        logic armed;
    } gate_state_t;

    gate_state_t s_d, s_q;

    always_comb begin
        s_d       = s_q;
        s_d.armed = s_q.armed | wrap_i;
        strobe_o  = !hold_i && (cnt_i == match_i) && (s_q.armed || wrap_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/phase_strobe_gen.sv
module phase_strobe_gen #(
    parameter int PHASE_W  = phstb_pkg::DEF_PHASE_W,
    parameter int SEL_W    = phstb_pkg::DEF_SEL_W,
    parameter int MIN_LOG2 = phstb_pkg::DEF_MIN_LOG2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PHASE_W-1:0] phase_cfg,
    input  logic [SEL_W-1:0]   ratio_sel,
    output logic               strobe_ch0,
    output logic               strobe_ch1,
    output logic [PHASE_W-1:0] delay_eff
);
    typedef struct packed {
        logic               fresh;
        logic [SEL_W-1:0]   sel;
        logic [PHASE_W-1:0] phase;
    } top_state_t;

    top_state_t s_d, s_q;

    logic [PHASE_W-1:0] last_w;
    logic [PHASE_W-1:0] match_w;
    logic [PHASE_W-1:0] cnt_w;
    logic               wrap_w;
    logic [SEL_W-1:0]   act_sel;

    // settings are taken on the load cycle after reset and at every period end
    always_comb begin
        s_d = s_q;
        if (s_q.fresh || wrap_w) begin
            s_d.fresh = 1'b0;
            s_d.sel   = ratio_sel;
            s_d.phase = phase_cfg;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.fresh <= 1'b1;
            s_q.sel   <= SEL_W'(phstb_pkg::RATIO_256);
            s_q.phase <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign act_sel = s_q.sel;

    phstb_decode #(
        .PHASE_W (PHASE_W),
        .SEL_W   (SEL_W),
        .MIN_LOG2(MIN_LOG2)
    ) u_decode (
        .phase_i(s_q.phase),
        .sel_i  (s_q.sel),
        .delay_o(delay_eff),
        .last_o (last_w),
        .match_o(match_w)
    );

    phstb_counter #(
        .CNT_W(PHASE_W)
    ) u_counter (
        .clk   (clk),
        .rst_n (rst_n),
        .hold_i(s_q.fresh),
        .last_i(last_w),
        .cnt_o (cnt_w),
        .wrap_o(wrap_w)
    );

    phstb_ch0_gate #(
        .CNT_W(PHASE_W)
    ) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .hold_i  (s_q.fresh),
        .wrap_i  (wrap_w),
        .cnt_i   (cnt_w),
        .match_i (match_w),
        .strobe_o(strobe_ch0)
    );

    assign strobe_ch1 = wrap_w;

endmodule

// File: rtl/phstb_checker.sv
module phstb_checker #(
    parameter int PHASE_W  = phstb_pkg::DEF_PHASE_W,
    parameter int SEL_W    = phstb_pkg::DEF_SEL_W,
    parameter int MIN_LOG2 = phstb_pkg::DEF_MIN_LOG2
) (
    input logic               clk,
    input logic               rst_n,
    input logic               strobe_ch0,
    input logic               strobe_ch1,
    input logic [PHASE_W-1:0] delay_eff,
    input logic [SEL_W-1:0]   act_sel
);
    logic [1:0]         age_q;
    logic               had_ch1_q;
    logic               ch0_seen_q;
    logic [PHASE_W:0]   gap_q;
    logic [PHASE_W:0]   osr_w;
    logic [PHASE_W-1:0] top_bits;
    logic               ext_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q      <= '0;
            had_ch1_q  <= 1'b0;
            ch0_seen_q <= 1'b0;
            gap_q      <= '0;
        end else begin
            if (age_q != 2'd2) age_q <= age_q + 2'd1;
            if (strobe_ch1) had_ch1_q <= 1'b1;
            gap_q      <= strobe_ch1 ? '0 : gap_q + 1'b1;
            ch0_seen_q <= strobe_ch1 ? 1'b0 : (ch0_seen_q | strobe_ch0);
        end
    end

    always_comb begin
        osr_w    = (PHASE_W+1)'(1) << (MIN_LOG2 + int'(act_sel));
        top_bits = PHASE_W'($signed(delay_eff) >>> (MIN_LOG2 + int'(act_sel) - 1));
        ext_ok   = (top_bits == '0) || (top_bits == '1);
    end

    AST_QUIET_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd0) |-> (!strobe_ch0 && !strobe_ch1)); // R1
    AST_CH1_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe_ch1 && had_ch1_q) |-> ((gap_q + 1'b1) == osr_w)); // R2
    AST_DELAY_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
        ext_ok); // R3
    AST_CH0_AFTER_CH1: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_ch0 |-> (had_ch1_q || strobe_ch1)); // R5
    AST_DELAY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        ((age_q == 2'd2) && !$past(strobe_ch1)) |-> $stable(delay_eff)); // R6
    AST_CH0_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_ch0 |-> !ch0_seen_q); // R7

endmodule

bind phase_strobe_gen phstb_checker #(
    .PHASE_W (PHASE_W),
    .SEL_W   (SEL_W),
    .MIN_LOG2(MIN_LOG2)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .strobe_ch0(strobe_ch0),
    .strobe_ch1(strobe_ch1),
    .delay_eff (delay_eff),
    .act_sel   (act_sel)
);

// File: tb/phase_strobe_gen_test.sv
module phase_strobe_gen_test;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 14;
    localparam int WD_LIMIT   = 20000;

    // {ratio_sel[17:16], phase_cfg[15:8], expected signed delay[7:0]}
    localparam logic [17:0] VEC [NVEC] = '{
        {2'd3, 8'h7F, 8'h7F}, {2'd3, 8'h80, 8'h80}, {2'd3, 8'h00, 8'h00},
        {2'd3, 8'hFF, 8'hFF}, {2'd3, 8'h01, 8'h01}, {2'd3, 8'h81, 8'h81},
        {2'd2, 8'hFF, 8'hFF}, {2'd2, 8'h40, 8'hC0}, {2'd2, 8'h3F, 8'h3F},
        {2'd1, 8'hA0, 8'hE0}, {2'd1, 8'h7E, 8'hFE}, {2'd0, 8'h0F, 8'h0F},
        {2'd0, 8'hF0, 8'hF0}, {2'd0, 8'h25, 8'h05}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] phase_cfg = 8'h00;
    logic [1:0] ratio_sel = 2'd3;
    logic       strobe_ch0;
    logic       strobe_ch1;
    logic [7:0] delay_eff;

    int n_cmp = 0;
    int n_bad = 0;
    int wd    = 0;
    int cyc   = 0;

    phase_strobe_gen uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .phase_cfg (phase_cfg),
        .ratio_sel (ratio_sel),
        .strobe_ch0(strobe_ch0),
        .strobe_ch1(strobe_ch1),
        .delay_eff (delay_eff)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        wd = wd + 1;
        if (wd > WD_LIMIT) begin
            n_cmp = n_cmp + 1;
            n_bad = n_bad + 1;
            $display("FAIL watchdog: actual %0d cycles expected at most %0d", wd, WD_LIMIT);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_cmp = n_cmp + 1;
        if (!ok) begin
            n_bad = n_bad + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc = cyc + 1;
    endtask

    function automatic int sdelay();
        return int'($signed(delay_eff));
    endfunction

    // reset with the given settings; on return cyc = 0 is the load cycle
    task automatic do_reset(input logic [1:0] sel, input logic [7:0] ph);
        @(negedge clk);
        rst_n     = 1'b0;
        ratio_sel = sel;
        phase_cfg = ph;
        repeat (2) @(negedge clk);
        chk(!strobe_ch0 && !strobe_ch1, "R1 strobes in reset", int'({strobe_ch0, strobe_ch1}), 0);
        chk(delay_eff == 8'h00, "R1 delay in reset", sdelay(), 0);
        rst_n = 1'b1;
        #1;
        chk(!strobe_ch0 && !strobe_ch1, "R1 strobes in load cycle", int'({strobe_ch0, strobe_ch1}), 0);
        cyc = 0;
    endtask

    task automatic run_vec(input int idx);
        logic [1:0] sel;
        logic [7:0] ph;
        int exp_d, osr, f1, s1, f0, exp_f0;
        sel   = VEC[idx][17:16];
        ph    = VEC[idx][15:8];
        exp_d = int'($signed(VEC[idx][7:0]));
        osr   = 1 << (5 + int'(sel));
        f1 = -1; s1 = -1; f0 = -1;
        do_reset(sel, ph);
        for (int c = 1; c <= 2 * osr + 4; c++) begin
            tick();
            if (c == 1) chk(sdelay() == exp_d, "R3 decoded delay", sdelay(), exp_d);
            if (strobe_ch0 && f0 < 0) begin
                f0 = cyc;
                chk(f1 >= 0 || strobe_ch1, "R5 ch0 before first ch1", cyc, -1);
            end
            if (strobe_ch1) begin
                if (f1 < 0) f1 = cyc;
                else if (s1 < 0) s1 = cyc;
            end
        end
        exp_f0 = osr + (((exp_d % osr) + osr) % osr);
        chk(f1 == osr, "R2 first ch1 pulse", f1, osr);
        chk(s1 == 2 * osr, "R2 second ch1 pulse", s1, 2 * osr);
        chk(f0 == exp_f0, "R4 first ch0 pulse", f0, exp_f0);
    endtask

    initial begin
        int f0, f1;
        for (int i = 0; i < NVEC; i++) run_vec(i);

        // R8: ratio change alone, phase 0xC5 held: -59 at OSR 256, +5 at OSR 64
        do_reset(2'd3, 8'hC5);
        repeat (100) tick();
        ratio_sel = 2'd1;
        tick();
        chk(sdelay() == -59, "R6 delay held after ratio change", sdelay(), -59);
        while (cyc < 256) tick();
        chk(strobe_ch1 == 1'b1, "R2 ch1 at end of old 256 period", int'(strobe_ch1), 1);
        chk(sdelay() == -59, "R6 delay held on boundary cycle", sdelay(), -59);
        tick();
        chk(sdelay() == 5, "R8 same setting read at new ratio", sdelay(), 5);
        f0 = -1; f1 = -1;
        while (cyc < 330) begin
            tick();
            if (strobe_ch0 && f0 < 0) f0 = cyc;
            if (strobe_ch1 && f1 < 0) f1 = cyc;
        end
        chk(f0 == 261, "R4 ch0 after ratio switch", f0, 261);
        chk(f1 == 320, "R8 period after ratio switch", f1, 320);

        // R6: phase change in mid-period, 0x3F at OSR 64 means -1
        phase_cfg = 8'h3F;
        while (cyc < 384) tick();
        chk(sdelay() == 5, "R6 delay held until boundary", sdelay(), 5);
        chk(strobe_ch1 == 1'b1, "R2 ch1 at boundary", int'(strobe_ch1), 1);
        tick();
        chk(sdelay() == -1, "R6 new phase in force", sdelay(), -1);
        f0 = -1; f1 = -1;
        while (cyc < 450) begin
            tick();
            if (strobe_ch0 && f0 < 0) f0 = cyc;
            if (strobe_ch1 && f1 < 0) f1 = cyc;
        end
        chk(f0 == 447, "R4 negative offset leads ch1", f0, 447);
        chk(f1 == 448, "R7 one ch0 before next ch1", f1, 448);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule